// File: doc/BRIEF.md
# Per-pin input deglitch filter with shared tick divider

This block sits between the synchronized pins of a 32-pin general-purpose I/O bank and the bank's interrupt detection. It removes short glitches from each pin before edge or level detection sees them. Each pin has its own filter, and two per-pin control bits set how that filter works. The first bit turns filtering on or off. The second bit chooses what samples the pin: either every reference clock edge, or a slow tick taken from one shared 24-bit divider.

An enabled filter moves its output to a new level only after two successive samples of the input agree on that level. In clock mode this rejects a pulse of one cycle. In tick mode it rejects any pulse shorter than one tick period. The tick period is 2×(N+1) reference cycles, where N is the value in the divider register. A write to that register restarts the divider, so software knows the sampling phase. A pin with filtering off is wired straight to its output.

The two per-pin control registers use a split-half masked write. The divider register is written as one plain word.

Top module: `gpio_deglitch`

## Requirements
- R1: A pin whose filter-enable bit is 0 drives its output from its input combinationally, in the same cycle.
- R2: A pin with filtering on and tick-select 0 samples its input on every clock edge. Its output takes a new level on the edge where the current sample equals the previous one, so a one-cycle pulse never reaches the output and a two-cycle pulse does.
- R3: The divider tick repeats every 2×(N+1) clock cycles, with N the divider value. A tick-mode pin therefore changes its output between 2(N+1)+1 and 4(N+1) edges after its input changes.
- R4: A write to the divider register restarts the divider. Counting the write edge as edge 1, a tick-mode pin whose input changes just after that edge takes the new level on edge 4(N+1)+1 and not earlier.
- R5: The divider register is at byte address 0x48. It takes one full write with no mask, keeps bits 23:0 only, and reads back with bits 31:24 as zero.
- R6: The filter-enable bits are at 0x38 (pins 15:0) and 0x3C (pins 31:16). The tick-select bits are at 0x40 (pins 15:0) and 0x44 (pins 31:16).
  - On a write to any of these addresses, data bits 31:16 are per-bit write strobes for the value bits 15:0.
  - A half-bit whose strobe is 0 keeps its old value.
  - A read of any of these addresses returns the half in bits 15:0, with bits 31:16 as zero.
- R7: After reset, all filter-enable and tick-select bits are 0 and the divider is 0. Each filter's stored sample and output take the current input, so the outputs equal the inputs.
- R8: Filtering and sampling choices are independent per pin. A clock-mode pin and a tick-mode pin react to the same input edge with their own latencies.
- R9: In tick mode, a pulse shorter than one tick period (2(N+1) cycles) never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_sync | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
The bench measures the exact edge on which a tick-mode pin settles after a divider write. A divider that failed to restart, or that ticked once per N+1 cycles instead of 2(N+1), would settle early or late.

In clock mode, the bench checks both pulse widths. A filter that took a single sample would pass the one-cycle pulse, and one that waited for three samples would block the two-cycle pulse.

A pulse of seven cycles against an eight-cycle tick checks that one tick sample is never enough.

The masked writes are read back, so a design that ignored the strobe half would clear bits it should have kept. A disabled pin is checked before any clock edge, which exposes a design that registers the bypass path.

// File: rtl/gpio_deglitch.sv
module gpio_deglitch #(
  parameter int PINS      = 32,
  parameter int DIVW      = 24,
  parameter int AW        = 8,
  parameter logic [AW-1:0] A_EN_LO  = 8'h38,
  parameter logic [AW-1:0] A_EN_HI  = 8'h3C,
  parameter logic [AW-1:0] A_SEL_LO = 8'h40,
  parameter logic [AW-1:0] A_SEL_HI = 8'h44,
  parameter logic [AW-1:0] A_DIV    = 8'h48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_sync,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [PINS-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [PINS-1:0] rd_data,
  output logic [PINS-1:0] pin_filt
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] flt_en, tick_sel, smp_q, filt_q, stb, take;
  logic [DIVW-1:0] div_n, cnt;
  logic            phase, tick, div_wr;

  wire [HALF-1:0] strb = wr_data[PINS-1:HALF];
  wire [HALF-1:0] wval = wr_data[HALF-1:0];

  assign div_wr = wr_en && (wr_addr == A_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_en   <= '0;
      tick_sel <= '0;
      div_n    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EN_LO:  flt_en[HALF-1:0]      <= (flt_en[HALF-1:0] & ~strb) | (wval & strb);
        A_EN_HI:  flt_en[PINS-1:HALF]   <= (flt_en[PINS-1:HALF] & ~strb) | (wval & strb);
        A_SEL_LO: tick_sel[HALF-1:0]    <= (tick_sel[HALF-1:0] & ~strb) | (wval & strb);
        A_SEL_HI: tick_sel[PINS-1:HALF] <= (tick_sel[PINS-1:HALF] & ~strb) | (wval & strb);
        A_DIV:    div_n                 <= wr_data[DIVW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_EN_LO:  rd_data = PINS'(flt_en[HALF-1:0]);
      A_EN_HI:  rd_data = PINS'(flt_en[PINS-1:HALF]);
      A_SEL_LO: rd_data = PINS'(tick_sel[HALF-1:0]);
      A_SEL_HI: rd_data = PINS'(tick_sel[PINS-1:HALF]);
      A_DIV:    rd_data = PINS'(div_n);
      default:  rd_data = '0;
    endcase
  end

  assign tick = phase && (cnt == div_n);

  always_ff @(posedge clk) begin
    if (!rst_n || div_wr) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == div_n) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign stb  = ~tick_sel | {PINS{tick}};
  assign take = ~flt_en | (stb & ~(pin_sync ^ smp_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q  <= pin_sync;
      filt_q <= pin_sync;
    end else begin
      smp_q  <= (pin_sync & (~flt_en | stb)) | (smp_q & flt_en & ~stb);
      filt_q <= (pin_sync & take) | (filt_q & ~take);
    end
  end

  assign pin_filt = (flt_en & filt_q) | (~flt_en & pin_sync);

  assert_sample_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((filt_q ^ $past(filt_q)) & ~$past(~flt_en | stb)) == '0);

  assert_new_level_from_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((filt_q ^ $past(filt_q)) & (filt_q ^ $past(pin_sync))) == '0);

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (cnt == '0) && !phase);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt <= div_n);
endmodule

// File: tb/gpio_deglitch_test.sv
module gpio_deglitch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_sync = 32'h5A5A5A5A;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h0;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  rd_addr = 8'h0;
  logic [31:0] rd_data, pin_filt;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  gpio_deglitch uut (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pin_filt(pin_filt)
  );

  // clock-mode table, all pins filtered: {input, expected output after the edge}
  localparam logic [63:0] VEC [12] = '{
    {32'hFFFF0000, 32'h00000000}, {32'hFFFF0000, 32'hFFFF0000},
    {32'hFFFF00FF, 32'hFFFF0000}, {32'h000000FF, 32'hFFFF00FF},
    {32'h000000FF, 32'h000000FF}, {32'h000000FF, 32'h000000FF},
    {32'h00000000, 32'h000000FF}, {32'hFFFFFFFF, 32'h000000FF},
    {32'h00000000, 32'h000000FF}, {32'h00000000, 32'h00000000},
    {32'hA5A5A5A5, 32'h00000000}, {32'hA5A5A5A5, 32'hA5A5A5A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lat;
    logic seen;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    // R7 reset state
    rd(8'h38, d); chk("R7 enable lo after reset", d, 32'h0);
    rd(8'h48, d); chk("R7 divider after reset", d, 32'h0);
    chk("R7 outputs equal inputs", pin_filt, 32'h5A5A5A5A);

    wr(8'h38, 32'hFFFFFFFF);
    wr(8'h3C, 32'hFFFFFFFF);
    chk("R7 enabling adds no edge", pin_filt, 32'h5A5A5A5A);
    pin_sync = 32'h0;
    step(); step();

    // R2 vector table
    for (int i = 0; i < 12; i++) begin
      pin_sync = VEC[i][63:32];
      step();
      chk($sformatf("R2 vector %0d", i), pin_filt, VEC[i][31:0]);
    end

    // R1 / R6 bypass and masked writes
    pin_sync = 32'h0;
    step(); step();
    wr(8'h3C, 32'hFFFF0000);
    rd(8'h3C, d); chk("R6 hi half cleared", d, 32'h0);
    rd(8'h38, d); chk("R6 lo half untouched", d, 32'h0000FFFF);
    pin_sync = 32'hFFFF0000;
    #1 chk("R1 bypass same cycle", pin_filt, 32'hFFFF0000);
    @(negedge clk);
    wr(8'h38, 32'h00010000);
    rd(8'h38, d); chk("R6 only strobed bit changes", d, 32'h0000FFFE);

    // R2 pulse widths, pin 1
    pin_sync = 32'hFFFF0002; step();
    chk("R2 one-cycle pulse edge1", pin_filt, 32'hFFFF0000);
    pin_sync = 32'hFFFF0000; step();
    chk("R2 one-cycle pulse edge2", pin_filt, 32'hFFFF0000);
    step();
    pin_sync = 32'hFFFF0002; step();
    chk("R2 two-cycle pulse first edge", pin_filt, 32'hFFFF0000);
    step();
    chk("R2 two-cycle pulse passes", pin_filt, 32'hFFFF0002);
    pin_sync = 32'hFFFF0000; step(); step();

    // R5 divider register
    wr(8'h48, 32'hFFFFFFFF);
    rd(8'h48, d); chk("R5 divider keeps 24 bits", d, 32'h00FFFFFF);

    // R4 restart, pin 2 in tick mode, N=3
    wr(8'h40, 32'h00040004);
    rd(8'h40, d); chk("R6 tick select readback", d, 32'h00000004);
    wr(8'h48, 32'd3);
    pin_sync = 32'hFFFF0004;
    repeat (15) step();
    chk("R4 not before edge 17", {31'h0, pin_filt[2]}, 32'h0);
    step();
    chk("R4 settles on edge 17", {31'h0, pin_filt[2]}, 32'h1);

    // R3 latency window, N=1
    wr(8'h48, 32'd1);
    repeat (3) step();
    pin_sync = 32'hFFFF0000;
    lat = 0;
    for (int k = 1; k <= 20 && lat == 0; k++) begin
      step();
      if (!pin_filt[2]) lat = k;
    end
    total++;
    if (lat < 5 || lat > 8) begin
      bad++;
      $display("FAIL R3: actual latency=%0d expected 5..8", lat);
    end

    // R9 short pulse in tick mode, N=3
    wr(8'h48, 32'd3);
    repeat (5) step();
    seen = 1'b0;
    pin_sync = 32'hFFFF0004;
    for (int k = 0; k < 30; k++) begin
      if (k == 7) pin_sync = 32'hFFFF0000;
      step();
      if (pin_filt[2]) seen = 1'b1;
    end
    chk("R9 pulse shorter than tick blocked", {31'h0, seen}, 32'h0);

    // R8 mixed modes: pin 1 clock, pin 2 tick
    pin_sync = 32'hFFFF0006;
    step(); step();
    chk("R8 clock pin fast, tick pin slow", {30'h0, pin_filt[2:1]}, 32'h1);
    repeat (20) step();
    chk("R8 both settled", {30'h0, pin_filt[2:1]}, 32'h3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule